// File: doc/BRIEF.md
# Throttle Ratio Search Engine

A clock-throttling controller holds a processor off its clock for a run of ON intervals, then lets it run for OFF intervals. The effective rate is the stock rate scaled by OFF / (ON + OFF). This block takes a requested rate and the stock rate, both in kHz. It searches every total period length from a programmed maximum down to 1 and returns the 8-bit ON and OFF counts whose achievable rate is nearest to the request.

Each candidate period needs two integer divisions. Both are done by one shared restoring divider, so every candidate costs the same number of cycles. A start pulse launches a search. Busy stays high while it runs, and a one-cycle done pulse marks the results as valid. If the best rate the search finds is the stock rate itself, throttling has to be switched off. The block then reports both counts as zero and raises a disable flag. Callers keep the stock rate nonzero and the request no larger than the stock rate.

Top module: `throttle_search`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, done_o, on_cnt_o, off_cnt_o, freq_khz_o and mod_off_o are all 0.
- R2: When start_i is high while the block is idle, the inputs are captured and busy_o is high from the next cycle onward. busy_o stays high until done_o pulses high for exactly one cycle, and busy_o is low in that done cycle.
- R3: A start_i pulse while busy_o is high is ignored, and so are input changes during a search. The reported results are those for the inputs captured at the accepted start.
- R4: The effective maximum period D is max_dur_i. A value of 0 is treated as 1, and any value above 255 is treated as 255.
- R5: For each period p from D down to 1 the candidate is off = floor(req·p / stock) mod 256, on = (p − off) mod 256 and rate = floor(stock·off / p). A reported non-disabled result satisfies on + off ≥ 1.
- R6: A candidate replaces the current best when |rate − req| ≤ |best − req|. On equal error the later, shorter period wins.
- R7: Before the scan the best is off = 1, on = 0, rate = stock. If no candidate comes as close as that, the stock rate is the result.
- R8: When the chosen rate equals the stock rate, on_cnt_o = off_cnt_o = 0 and mod_off_o = 1. Otherwise mod_off_o = 0 and the counts are those of the chosen candidate.
- R9: The number of cycles from start to done depends only on D, and not on the request or the stock rate.
- R10: The results stay constant from a done pulse until the next done pulse, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a search when idle |
| req_khz_i | input | FREQ_W | Requested rate in kHz |
| stock_khz_i | input | FREQ_W | Unthrottled rate in kHz, nonzero |
| max_dur_i | input | DUR_W | Longest period to try, in intervals |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse, results valid |
| on_cnt_o | output | CNT_W | Chosen clock-stopped interval count |
| off_cnt_o | output | CNT_W | Chosen clock-running interval count |
| freq_khz_o | output | FREQ_W | Achieved rate in kHz |
| mod_off_o | output | 1 | Throttling must be disabled |

## Verification
The search is run with the following input patterns:
- An exact half ratio, where several periods hit the request with zero error. This shows whether ties go to the shorter period.
- A request that falls between two achievable steps. This checks both the truncating division and the closer-match choice.
- A request equal to the stock rate, and a request above half the stock rate with a period limit of 1. These separate a chosen stock rate from the kept initial best, and both must raise the disable flag.
- A zero request, and a period limit of 0. These give zero OFF counts.
- A large odd stock rate, checked against hand-worked values.
- Limits of 255 and 300, compared against an independent model and against each other. This shows the clamp.

Run lengths are compared between searches that share a period limit. A start pulse is also injected mid-search.

// File: rtl/throttle_pkg.sv
package throttle_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OFF_DIV,
    ST_OFF_WAIT,
    ST_FRQ_WAIT,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/throttle_div.sv
// Restoring divider, one quotient bit per cycle, fixed latency of DVD_W cycles.
module throttle_div #(
  parameter int DVD_W = 28,
  parameter int DVS_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);
  localparam int CW = $clog2(DVD_W + 1);

  logic [CW-1:0]    cnt_q;
  logic [DVS_W-1:0] rem_q, dvs_q;
  logic [DVD_W-1:0] dvd_q, quo_q;
  logic             done_q;
  logic [DVS_W:0]   trial, diff;
  logic             fits;

  assign trial = {rem_q, dvd_q[DVD_W-1]};
  assign fits  = trial >= {1'b0, dvs_q};
  assign diff  = trial - {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      quo_q  <= '0;
      done_q <= 1'b0;
    end else if (go_i) begin
      cnt_q  <= CW'(DVD_W);
      rem_q  <= '0;
      dvs_q  <= divisor_i;
      dvd_q  <= dividend_i;
      quo_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q  <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
      quo_q  <= {quo_q[DVD_W-2:0], fits};
      dvd_q  <= {dvd_q[DVD_W-2:0], 1'b0};
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
endmodule

// File: rtl/throttle_err_cmp.sv
// Decides whether a candidate rate is at least as close to the target as the best so far.
module throttle_err_cmp #(
  parameter int W = 20
) (
  input  logic [W-1:0] cand_i,
  input  logic [W-1:0] best_i,
  input  logic [W-1:0] target_i,
  output logic         take_o
);
  logic [W-1:0] err_cand, err_best;

  assign err_cand = (cand_i >= target_i) ? cand_i - target_i : target_i - cand_i;
  assign err_best = (best_i >= target_i) ? best_i - target_i : target_i - best_i;
  assign take_o   = err_cand <= err_best;
endmodule

// File: rtl/throttle_seq.sv
module throttle_seq
  import throttle_pkg::*;
#(
  parameter int FREQ_W = 20,
  parameter int DUR_W  = 9,
  parameter int CNT_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [FREQ_W-1:0]       req_i,
  input  logic [FREQ_W-1:0]       stock_i,
  input  logic [DUR_W-1:0]        max_dur_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [CNT_W-1:0]        on_o,
  output logic [CNT_W-1:0]        off_o,
  output logic [FREQ_W-1:0]       freq_o,
  output logic                    mod_off_o,
  output logic                    div_go_o,
  output logic [FREQ_W+CNT_W-1:0] div_dvd_o,
  output logic [FREQ_W-1:0]       div_dvs_o,
  input  logic                    div_done_i,
  input  logic [FREQ_W+CNT_W-1:0] div_quo_i,
  output logic [FREQ_W-1:0]       cand_o,
  output logic [FREQ_W-1:0]       best_o,
  output logic [FREQ_W-1:0]       target_o,
  input  logic                    take_i
);
  localparam int PROD_W  = FREQ_W + CNT_W;
  localparam int MAX_DUR = (1 << CNT_W) - 1;

  seq_st_e            st_q;
  logic [FREQ_W-1:0]  req_q, stock_q, best_frq_q, cand;
  logic [CNT_W-1:0]   idx_q, off_c_q, best_on_q, best_off_q, dur_eff;

  // 0 -> 1, above the count range -> full range
  always_comb begin
    if (max_dur_i == '0)                    dur_eff = CNT_W'(1);
    else if (max_dur_i > DUR_W'(MAX_DUR))   dur_eff = CNT_W'(MAX_DUR);
    else                                    dur_eff = max_dur_i[CNT_W-1:0];
  end

  assign cand = (|div_quo_i[PROD_W-1:FREQ_W]) ? '1 : div_quo_i[FREQ_W-1:0];

  always_comb begin
    div_go_o  = (st_q == ST_OFF_DIV) || ((st_q == ST_OFF_WAIT) && div_done_i);
    if (st_q == ST_OFF_DIV) begin
      div_dvd_o = PROD_W'(req_q) * PROD_W'(idx_q);
      div_dvs_o = stock_q;
    end else begin
      div_dvd_o = PROD_W'(stock_q) * PROD_W'(div_quo_i[CNT_W-1:0]);
      div_dvs_o = FREQ_W'(idx_q);
    end
  end

  assign cand_o   = cand;
  assign best_o   = best_frq_q;
  assign target_o = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      req_q      <= '0;
      stock_q    <= '0;
      idx_q      <= '0;
      off_c_q    <= '0;
      best_on_q  <= '0;
      best_off_q <= '0;
      best_frq_q <= '0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      on_o       <= '0;
      off_o      <= '0;
      freq_o     <= '0;
      mod_off_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            req_q      <= req_i;
            stock_q    <= stock_i;
            idx_q      <= dur_eff;
            best_on_q  <= '0;
            best_off_q <= CNT_W'(1);
            best_frq_q <= stock_i;
            busy_o     <= 1'b1;
            st_q       <= ST_OFF_DIV;
          end
        end
        ST_OFF_DIV: st_q <= ST_OFF_WAIT;
        ST_OFF_WAIT: begin
          if (div_done_i) begin
            off_c_q <= div_quo_i[CNT_W-1:0];
            st_q    <= ST_FRQ_WAIT;
          end
        end
        ST_FRQ_WAIT: begin
          if (div_done_i) begin
            if (take_i) begin
              best_on_q  <= idx_q - off_c_q;
              best_off_q <= off_c_q;
              best_frq_q <= cand;
            end
            if (idx_q == CNT_W'(1)) begin
              st_q <= ST_DONE;
            end else begin
              idx_q <= idx_q - 1'b1;
              st_q  <= ST_OFF_DIV;
            end
          end
        end
        ST_DONE: begin
          if (best_frq_q == stock_q) begin
            on_o      <= '0;
            off_o     <= '0;
            mod_off_o <= 1'b1;
          end else begin
            on_o      <= best_on_q;
            off_o     <= best_off_q;
            mod_off_o <= 1'b0;
          end
          freq_o <= best_frq_q;
          done_o <= 1'b1;
          busy_o <= 1'b0;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/throttle_search.sv
module throttle_search #(
  parameter int FREQ_W = 20,
  parameter int DUR_W  = 9,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] req_khz_i,
  input  logic [FREQ_W-1:0] stock_khz_i,
  input  logic [DUR_W-1:0]  max_dur_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  on_cnt_o,
  output logic [CNT_W-1:0]  off_cnt_o,
  output logic [FREQ_W-1:0] freq_khz_o,
  output logic              mod_off_o
);
  localparam int PROD_W = FREQ_W + CNT_W;

  logic              div_go, div_done, take;
  logic [PROD_W-1:0] div_dvd, div_quo;
  logic [FREQ_W-1:0] div_dvs, cand, best, target;

  throttle_seq #(.FREQ_W(FREQ_W), .DUR_W(DUR_W), .CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .req_i      (req_khz_i),
    .stock_i    (stock_khz_i),
    .max_dur_i  (max_dur_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .on_o       (on_cnt_o),
    .off_o      (off_cnt_o),
    .freq_o     (freq_khz_o),
    .mod_off_o  (mod_off_o),
    .div_go_o   (div_go),
    .div_dvd_o  (div_dvd),
    .div_dvs_o  (div_dvs),
    .div_done_i (div_done),
    .div_quo_i  (div_quo),
    .cand_o     (cand),
    .best_o     (best),
    .target_o   (target),
    .take_i     (take)
  );

  throttle_div #(.DVD_W(PROD_W), .DVS_W(FREQ_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (div_go),
    .dividend_i (div_dvd),
    .divisor_i  (div_dvs),
    .done_o     (div_done),
    .quot_o     (div_quo)
  );

  throttle_err_cmp #(.W(FREQ_W)) u_cmp (
    .cand_i   (cand),
    .best_i   (best),
    .target_i (target),
    .take_o   (take)
  );
endmodule

// File: rtl/throttle_search_chk.sv
module throttle_search_chk #(
  parameter int FREQ_W = 20,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  on_cnt_o,
  input logic [CNT_W-1:0]  off_cnt_o,
  input logic [FREQ_W-1:0] freq_khz_o,
  input logic              mod_off_o
);
  // R2
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
  // R2
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R8
  disable_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mod_off_o) |-> (on_cnt_o == '0 && off_cnt_o == '0));
  // R5
  period_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !mod_off_o) |-> (({1'b0, on_cnt_o} + {1'b0, off_cnt_o}) != '0));
  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(on_cnt_o) && $stable(off_cnt_o) && $stable(freq_khz_o) && $stable(mod_off_o)));
endmodule

bind throttle_search throttle_search_chk #(.FREQ_W(FREQ_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .on_cnt_o   (on_cnt_o),
  .off_cnt_o  (off_cnt_o),
  .freq_khz_o (freq_khz_o),
  .mod_off_o  (mod_off_o)
);

// File: tb/throttle_search_test.sv
module throttle_search_test;
  localparam int FREQ_W = 20;
  localparam int DUR_W  = 9;
  localparam int CNT_W  = 8;
  localparam int NVEC   = 7;
  localparam int LIMIT  = 40000;

  // stock, req, max_dur, on, off, freq, disable
  localparam int VEC [NVEC][7] = '{
    '{1000,  500,  4, 1, 1,  500, 0},   // R6 tie -> shorter period
    '{1000,  1000, 3, 0, 0,  1000, 1},  // R8 stock reached
    '{1000,  300,  5, 3, 1,  250, 0},   // R5 truncation between steps
    '{1000,  400,  0, 1, 0,  0, 0},     // R4 zero limit acts as 1
    '{1000,  0,    2, 1, 0,  0, 0},     // R5 zero request
    '{33333, 10000, 7, 5, 2, 9523, 0},  // R5 odd stock rate
    '{1000,  700,  1, 0, 0,  1000, 1}   // R7 initial best kept
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [FREQ_W-1:0] req = '0, stock = '0;
  logic [DUR_W-1:0]  mdur = '0;
  logic              busy, done, mod_off;
  logic [CNT_W-1:0]  on_cnt, off_cnt;
  logic [FREQ_W-1:0] freq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  throttle_search #(.FREQ_W(FREQ_W), .DUR_W(DUR_W), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .req_khz_i(req), .stock_khz_i(stock), .max_dur_i(mdur),
    .busy_o(busy), .done_o(done), .on_cnt_o(on_cnt), .off_cnt_o(off_cnt),
    .freq_khz_o(freq), .mod_off_o(mod_off)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model(input int st, input int rq, input int md,
                                output int on, output int off, output int f, output int flg);
    int d;
    int bo, bf, bn;
    d  = (md == 0) ? 1 : ((md > 255) ? 255 : md);
    bn = 0; bo = 1; bf = st;
    for (int p = d; p >= 1; p--) begin
      int o, n, cf, ec, eb;
      o  = ((rq * p) / st) & 255;
      n  = (p - o) & 255;
      cf = (st * o) / p;
      ec = (cf > rq) ? cf - rq : rq - cf;
      eb = (bf > rq) ? bf - rq : rq - bf;
      if (ec <= eb) begin bn = n; bo = o; bf = cf; end
    end
    if (bf == st) begin on = 0; off = 0; flg = 1; end
    else begin on = bn; off = bo; flg = 0; end
    f = bf;
  endfunction

  // Launch a search; optionally inject a second start with other inputs mid-run.
  task automatic run(input int st, input int rq, input int md, input bit poke, output int cyc);
    bit dropped;
    dropped = 1'b0;
    @(negedge clk);
    stock = FREQ_W'(st); req = FREQ_W'(rq); mdur = DUR_W'(md); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", busy, 1);
    cyc = 0;
    while (!done && cyc < LIMIT) begin
      if (!busy) dropped = 1'b1;
      if (poke && cyc == 5) begin
        start = 1'b1; stock = 20'd33333; req = 20'd10000; mdur = 9'd7;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (cyc >= LIMIT) check(1'b0, "watchdog", cyc, LIMIT);
    check(!dropped, "R2 busy held", dropped, 0);
    check(busy == 1'b0, "R2 busy low at done", busy, 0);
  endtask

  task automatic expect_res(input string tag, input int on, input int off, input int f, input int flg);
    check(on_cnt == CNT_W'(on), {tag, " on"}, on_cnt, on);
    check(off_cnt == CNT_W'(off), {tag, " off"}, off_cnt, off);
    check(freq == FREQ_W'(f), {tag, " freq"}, freq, f);
    check(mod_off == flg[0], {tag, " disable"}, mod_off, flg);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cyc_a, cyc_b, e_on, e_off, e_f, e_flg;
    // R1 reset state
    repeat (3) @(negedge clk);
    check({busy, done, mod_off} == 3'b000, "R1 flags in reset", {busy, done, mod_off}, 0);
    check(on_cnt == 0 && off_cnt == 0 && freq == 0, "R1 results in reset", freq, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, done, mod_off} == 3'b000, "R1 flags after reset", {busy, done, mod_off}, 0);
    check(on_cnt == 0 && off_cnt == 0 && freq == 0, "R1 results after reset", freq, 0);

    // Table walk: R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      run(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0, cyc_a);
      expect_res($sformatf("R5/R6/R7/R8 vec%0d", v), VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);
      @(negedge clk);
      check(done == 1'b0, "R2 done one cycle", done, 0);
    end

    // R3 start during busy ignored
    run(1000, 300, 5, 1'b1, cyc_a);
    expect_res("R3 ignored start", 3, 1, 250, 0);

    // R10 hold while idle with changing inputs
    stock = 20'd5000; req = 20'd1234; mdur = 9'd9;
    repeat (10) @(negedge clk);
    check(done == 1'b0, "R10 no done", done, 0);
    expect_res("R10 held", 3, 1, 250, 0);

    // R9 latency independent of rates
    run(1000, 500, 4, 1'b0, cyc_a);
    run(33333, 12345, 4, 1'b0, cyc_b);
    check(cyc_a == cyc_b, "R9 latency same limit", cyc_b, cyc_a);
    run(1000, 400, 0, 1'b0, cyc_a);
    run(7777, 100, 1, 1'b0, cyc_b);
    check(cyc_a == cyc_b, "R4 zero limit latency", cyc_b, cyc_a);

    // R4 clamp and full search vs model
    model(200000, 77777, 255, e_on, e_off, e_f, e_flg);
    run(200000, 77777, 255, 1'b0, cyc_a);
    expect_res("R5 full search", e_on, e_off, e_f, e_flg);
    run(200000, 77777, 300, 1'b0, cyc_b);
    expect_res("R4 clamp result", e_on, e_off, e_f, e_flg);
    check(cyc_a == cyc_b, "R4 clamp latency", cyc_b, cyc_a);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule